// File: doc/BRIEF.md
# Stream Receive Packet Queue with Frame Length Readout

This block takes frames from a valid/ready stream slave and keeps their payload as whole data words in an internal buffer. It tracks every frame's byte count and routing tag, and queues them as small descriptors. A host works through plain pulse-and-value pins. It first checks the occupancy, which counts only words of complete frames. It then pulses the length read, which makes the next frame current and shows that frame's byte count and destination. Finally it pulses the data read once per word of that frame.

Back-pressure follows the usual valid/ready rules. A beat transfers on a rising clock edge where `s_valid` and `s_ready` are both high. The sender holds the beat stable while `s_ready` is low. `s_ready` drops while either the word buffer or the descriptor queue has no free entry. A host flush needs a matching key value. It empties every store and raises a sticky flush-done flag. Three sticky status flags (frame stored, flush done, read underrun) are cleared by writing ones on `sts_clr`.

Top module: `rx_pkt_queue`

## Requirements
- R1: `s_ready` is low whenever the word buffer (DATA_DEPTH words) or the descriptor queue (DESC_DEPTH frames) is full. A beat is taken only on a clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, held beats change nothing.
- R2: `occupancy` equals the number of words that belong to fully received frames and have not yet been read. A frame whose last beat has not arrived adds nothing. The value is 0 after reset.
- R3: A `len_rd` pulse while the current frame has no words left takes the next descriptor. One cycle later `frame_len` shows that frame's byte count, which is the sum of set `s_keep` bits over all its beats. If no descriptor is waiting, `frame_len` becomes 0.
- R4: A `len_rd` pulse while the current frame still has unread words is ignored. `frame_len`, `frame_dest` and `occupancy` stay unchanged and no descriptor is taken.
- R5: `frame_dest` is the `s_dest` value sampled on the last beat of the frame made current by the latest successful length read. It stays unchanged until the next successful length read or flush.
- R6: A `data_rd` pulse while the current frame has words left returns the next word in arrival order on `rd_data` one cycle later, and lowers `occupancy` by 1.
- R7: A `data_rd` pulse with no words left in the current frame returns 0 on `rd_data`, sets `sts_underrun`, and leaves `occupancy` unchanged.
- R8: A `rst_wr` pulse with `rst_key` equal to RESET_KEY (0x000000A5) discards all stored words, descriptors and any partial frame. It also sets `occupancy` and `frame_len` to 0 and sets `sts_rst_done`. A pulse with any other key has no effect.
- R9: `sts_rx_done` is set one cycle after a last beat is accepted. Each status flag is cleared by a 1 in its `sts_clr` bit: bit 0 for rx_done, bit 1 for rst_done, bit 2 for underrun. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when high |
| s_data | input | DATA_W | Stream beat payload |
| s_keep | input | DATA_W/8 | Byte-valid mask of the beat |
| s_last | input | 1 | Last beat of frame |
| s_dest | input | DEST_W | Routing tag, sampled on the last beat |
| occupancy | output | log2(DATA_DEPTH)+1 | Readable words of complete frames |
| len_rd | input | 1 | Length read pulse |
| frame_len | output | 16 | Byte count of current frame |
| frame_dest | output | DEST_W | Routing tag of current frame |
| data_rd | input | 1 | Data word read pulse |
| rd_data | output | DATA_W | Word returned by the last data read |
| rst_wr | input | 1 | Flush request pulse |
| rst_key | input | 32 | Key accompanying the flush request |
| sts_clr | input | 3 | Write-one-to-clear for status flags |
| sts_rx_done | output | 1 | Sticky: a frame was stored |
| sts_rst_done | output | 1 | Sticky: a flush completed |
| sts_underrun | output | 1 | Sticky: data read beyond frame end |

## Verification
A wrong remaining-word count shows up at the first read past the frame's true end. Such a read either returns the next frame's first word instead of 0, or returns 0 too early, and the scoreboard catches either one within a single read. A wrong occupancy sum shows up at the next complete frame or the next read, because the bench compares it after each one. A descriptor queue that pops on an ignored length read shifts every later `frame_len` and `frame_dest`. The next length read exposes that.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LEN_W  = 16;
  localparam int DEST_W = 4;

  typedef struct packed {
    logic [LEN_W-1:0]  bytes;
    logic [LEN_W-1:0]  words;
    logic [DEST_W-1:0] dest;
  } rxq_desc_t;

  localparam int DESC_W = $bits(rxq_desc_t);
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic [AW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxq_ingest.sv
module rxq_ingest
  import rxq_pkg::*;
#(
  parameter int KEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              beat,
  input  logic [KEEP_W-1:0] keep,
  input  logic              last,
  input  logic [DEST_W-1:0] dest,
  output logic              desc_push,
  output rxq_desc_t         desc
);
  logic [LEN_W-1:0] acc_bytes, acc_words;
  logic [LEN_W-1:0] keep_cnt;

  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < KEEP_W; i++) keep_cnt = keep_cnt + LEN_W'(keep[i]);
  end

  assign desc_push  = beat && last && !flush;
  assign desc.bytes = acc_bytes + keep_cnt;
  assign desc.words = acc_words + 1'b1;
  assign desc.dest  = dest;

  always_ff @(posedge clk) begin
    if (!rst_n || flush || (beat && last)) begin
      acc_bytes <= '0;
      acc_words <= '0;
    end else if (beat) begin
      acc_bytes <= desc.bytes;
      acc_words <= desc.words;
    end
  end
endmodule

// File: rtl/rx_pkt_queue.sv
module rx_pkt_queue
  import rxq_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          DATA_DEPTH = 16,
  parameter int          DESC_DEPTH = 4,
  parameter logic [31:0] RESET_KEY  = 32'h0000_00A5,
  localparam int KEEP_W = DATA_W / 8,
  localparam int DAW    = $clog2(DATA_DEPTH),
  localparam int QAW    = $clog2(DESC_DEPTH),
  localparam int OCC_W  = DAW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic [KEEP_W-1:0] s_keep,
  input  logic              s_last,
  input  logic [DEST_W-1:0] s_dest,
  output logic [OCC_W-1:0]  occupancy,
  input  logic              len_rd,
  output logic [LEN_W-1:0]  frame_len,
  output logic [DEST_W-1:0] frame_dest,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rst_wr,
  input  logic [31:0]       rst_key,
  input  logic [2:0]        sts_clr,
  output logic              sts_rx_done,
  output logic              sts_rst_done,
  output logic              sts_underrun
);
  logic              flush, beat;
  logic              d_full, d_empty, q_full, q_empty;
  logic [DAW:0]      d_cnt;
  logic [QAW:0]      q_cnt;
  logic [DATA_W-1:0] d_out;
  logic              desc_push, desc_pop, data_pop, under;
  rxq_desc_t         desc_in, desc_head;
  logic [LEN_W-1:0]  remain;

  assign flush    = rst_wr && (rst_key == RESET_KEY);
  assign s_ready  = !d_full && !q_full;
  assign beat     = s_valid && s_ready && !flush;
  assign desc_pop = len_rd && (remain == '0) && !q_empty && !flush;
  assign data_pop = data_rd && (remain != '0) && !flush;
  assign under    = data_rd && (remain == '0) && !flush;

  rxq_fifo #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data (
    .clk, .rst_n, .flush, .push(beat), .din(s_data), .pop(data_pop),
    .dout(d_out), .full(d_full), .empty(d_empty), .count(d_cnt));

  rxq_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_desc (
    .clk, .rst_n, .flush, .push(desc_push), .din(desc_in), .pop(desc_pop),
    .dout(desc_head), .full(q_full), .empty(q_empty), .count(q_cnt));

  rxq_ingest #(.KEEP_W(KEEP_W)) u_ing (
    .clk, .rst_n, .flush, .beat, .keep(s_keep), .last(s_last),
    .dest(s_dest), .desc_push, .desc(desc_in));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      remain     <= '0;
      frame_len  <= '0;
      frame_dest <= '0;
      rd_data    <= '0;
      occupancy  <= '0;
    end else begin
      if (desc_pop) begin
        remain     <= desc_head.words;
        frame_len  <= desc_head.bytes;
        frame_dest <= desc_head.dest;
      end else if (len_rd && remain == '0) begin
        frame_len  <= '0;
      end else if (data_pop) begin
        remain     <= remain - 1'b1;
      end
      if (data_pop)   rd_data <= d_out;
      else if (under) rd_data <= '0;
      occupancy <= occupancy + (desc_push ? OCC_W'(desc_in.words) : '0)
                             - OCC_W'(data_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_rx_done  <= 1'b0;
      sts_rst_done <= 1'b0;
      sts_underrun <= 1'b0;
    end else begin
      sts_rx_done  <= desc_push || (sts_rx_done  && !sts_clr[0]);
      sts_rst_done <= flush     || (sts_rst_done && !sts_clr[1]);
      sts_underrun <= under     || (sts_underrun && !sts_clr[2]);
    end
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(d_cnt));

  // R5
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(desc_pop) && !$past(flush) |-> $stable(frame_dest));

  // R7
  underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> sts_underrun && rd_data == '0);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occupancy == '0 && frame_len == '0 && sts_rst_done && q_cnt == '0);

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_push |=> sts_rx_done);
endmodule

// File: tb/sim_rx_pkt_queue.sv
module sim_rx_pkt_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 0, s_last = 0, len_rd = 0, data_rd = 0, rst_wr = 0;
  logic [31:0] s_data = '0, rst_key = '0;
  logic [3:0]  s_keep = '0, s_dest = '0;
  logic [2:0]  sts_clr = '0;
  logic        s_ready, sts_rx_done, sts_rst_done, sts_underrun;
  logic [4:0]  occupancy;
  logic [15:0] frame_len;
  logic [3:0]  frame_dest;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;
  logic [31:0] exp_q [$];

  always #2 clk = ~clk;

  rx_pkt_queue u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one beat, waits for acceptance, records word for the scoreboard
  task automatic beat(logic [31:0] d, logic [3:0] k, logic l, logic [3:0] dst);
    @(negedge clk);
    s_valid = 1; s_data = d; s_keep = k; s_last = l; s_dest = dst;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic pulse_len();
    @(negedge clk); len_rd = 1;
    @(negedge clk); len_rd = 0;
  endtask

  // monitor side: pops the expected word and compares with the returned one
  task automatic read_word(string req);
    logic [31:0] e;
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    e = exp_q.pop_front();
    chk(req, rd_data, e);
  endtask

  task automatic flush_req(logic [31:0] key);
    @(negedge clk); rst_wr = 1; rst_key = key;
    @(negedge clk); rst_wr = 0;
  endtask

  task automatic clear(logic [2:0] b);
    @(negedge clk); sts_clr = b;
    @(negedge clk); sts_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset occ", occupancy, 0);
    chk("R1 reset ready", s_ready, 1);
    chk("R9 reset status", {sts_rx_done, sts_rst_done, sts_underrun}, 0);

    beat(32'h11, 4'hF, 0, 4'd5);
    beat(32'h22, 4'hF, 0, 4'd5);
    beat(32'h33, 4'h3, 1, 4'd5);
    @(negedge clk);
    chk("R2 occ after frame A", occupancy, 3);
    chk("R9 rx_done set", sts_rx_done, 1);

    beat(32'h44, 4'hF, 0, 4'd9);
    beat(32'h55, 4'hF, 0, 4'd9);
    chk("R2 partial not counted", occupancy, 3);

    pulse_len();
    chk("R3 len A", frame_len, 10);
    chk("R5 dest A", frame_dest, 5);
    pulse_len();
    chk("R4 len held", frame_len, 10);
    chk("R4 occ held", occupancy, 3);

    beat(32'h66, 4'h1, 1, 4'd2);
    @(negedge clk);
    chk("R5 dest held across new frame", frame_dest, 5);
    chk("R2 occ two frames", occupancy, 6);

    read_word("R6 word A0");
    read_word("R6 word A1");
    read_word("R6 word A2");
    chk("R6 occ after reads", occupancy, 3);

    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    chk("R7 underrun data", rd_data, 0);
    chk("R7 underrun flag", sts_underrun, 1);
    chk("R7 occ unchanged", occupancy, 3);
    clear(3'b100);
    chk("R9 underrun cleared", sts_underrun, 0);
    clear(3'b001);
    chk("R9 rx_done cleared", sts_rx_done, 0);

    pulse_len();
    chk("R3 len B", frame_len, 9);
    chk("R5 dest B", frame_dest, 2);
    read_word("R6 word B0");
    read_word("R6 word B1");
    read_word("R6 word B2");
    pulse_len();
    chk("R3 len empty queue", frame_len, 0);

    for (int i = 0; i < 4; i++) beat(32'hA0 + i, 4'hF, 1, 4'(i));
    @(negedge clk);
    chk("R1 ready low desc full", s_ready, 0);
    s_valid = 1; s_data = 32'hDEAD; s_last = 1;
    repeat (3) @(negedge clk);
    s_valid = 0; s_last = 0;
    chk("R1 held beat ignored", occupancy, 4);

    flush_req(32'h0000_005A);
    chk("R8 wrong key ignored", occupancy, 4);
    chk("R8 wrong key no done", sts_rst_done, 0);
    flush_req(32'h0000_00A5);
    exp_q.delete();
    chk("R8 flush occ", occupancy, 0);
    chk("R8 flush done", sts_rst_done, 1);
    chk("R1 ready after flush", s_ready, 1);
    pulse_len();
    chk("R8 no descriptors after flush", frame_len, 0);
    clear(3'b010);
    chk("R9 rst_done cleared", sts_rst_done, 0);

    for (int i = 0; i < 16; i++) beat(32'hB0 + i, 4'hF, 0, 4'd1);
    @(negedge clk);
    chk("R1 ready low data full", s_ready, 0);
    chk("R2 unfinished frame not counted", occupancy, 0);
    flush_req(32'h0000_00A5);
    exp_q.delete();
    chk("R8 flush partial ready", s_ready, 1);

    beat(32'hC7, 4'h7, 1, 4'd7);
    @(negedge clk);
    chk("R2 occ single beat", occupancy, 1);
    pulse_len();
    chk("R3 len partial keep", frame_len, 3);
    chk("R5 dest C", frame_dest, 7);
    read_word("R6 word C0");
    chk("R6 occ drained", occupancy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule